// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers seven single-cycle event pulses into one pending-interrupt register, filters them through an enable register, and raises one level-sensitive interrupt line while any enabled source is pending. Beside the line it reports the number of the highest-numbered enabled pending source together with a valid flag. Software can therefore service sources from the top bit downwards without scanning the register itself.

Both registers sit on a simple register bus with a select strobe, a write strobe, a byte address and a 32-bit data word. The pending register is a plain read/write register and not write-one-to-clear. A written bit takes the written value, so software can raise an interrupt by writing a 1. It clears a source by writing back the register with that bit at zero. A hardware event that coincides with such a write still lands. Read data comes back one cycle after the request, qualified by a valid pin. The bus has no back-pressure: every request is taken in the cycle it is presented, so there is no ready pin.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset the pending and enable registers are zero, the interrupt line and the index valid flag are low, the index is 0 and read valid is low.
- R2: A write with address 0x50 loads bits 6..0 of the data word into the pending register exactly: 1 sets a bit, 0 clears it.
- R3: A write with address 0x54 loads bits 6..0 into the enable register; an enable bit of 1 lets its source through and 0 blocks it.
- R4: The interrupt line is high in exactly those cycles in which the AND of pending and enable registers is nonzero.
- R5: The index output gives the position (0..6) of the highest set bit of pending AND enable, the valid flag is high exactly when that AND is nonzero, and the index is 0 when the flag is low.
- R6: A pulse on event input bit i sets pending bit i at the next clock edge, whatever the enable bit.
- R7: When an event pulse and a pending-register write fall in the same cycle, the event's bit is set after the write, so the event is never lost.
- R8: Bits 31..7 of both registers read as zero, and writing ones to them changes nothing.
- R9: A read returns the register value from before that cycle's edge one cycle after the request, with read valid high for exactly that cycle; addresses other than 0x50 and 0x54 read as zero and ignore writes, and reads never change either register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | 7 | One-cycle event pulses, bit i for source i |
| bus_en | input | 1 | Register access request in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when read valid is low |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq_out | output | 1 | Level interrupt, high while an enabled source is pending |
| irq_idx | output | 3 | Highest-numbered enabled pending source |
| irq_idx_vld | output | 1 | The index output is meaningful |

## Verification
On every cycle the assertions check that the interrupt line and the index valid flag agree, that the index rests at zero when nothing is pending, that every event pulse shows in the pending register one edge later even under a simultaneous write, that read valid follows a read request by exactly one cycle, that unused upper bits read as zero, and that a read with no event leaves both registers untouched. Only the bench's scenarios can show the exact written values of the pending and enable registers, the correct priority among several pending sources, that unmapped addresses ignore writes, and that reads return the value from before the edge.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

  // Which register a bus access targets after address decode.
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_MASK  = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile #(
  parameter int N_SRC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cause,
  input  logic             wr_mask,
  input  logic [N_SRC-1:0] wdata,
  input  logic [N_SRC-1:0] src_evt,
  output logic [N_SRC-1:0] cause_q,
  output logic [N_SRC-1:0] mask_q
);

  // Pending bits: the bus write is applied first, the event is ORed on top.
  for (genvar i = 0; i < N_SRC; i++) begin : g_cause
    logic base_d;
    always_comb base_d = wr_cause ? wdata[i] : cause_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q[i] <= 1'b0;
      else        cause_q[i] <= base_d | src_evt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wdata;
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 7,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             vld
);

  // Scan upward so the last hit is the highest set bit.
  always_comb begin
    idx = '0;
    vld = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        idx = IDX_W'(i);
        vld = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port
  import irq_cause_pkg::*;
#(
  parameter int N_SRC  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [N_SRC-1:0]  cause,
  input  logic [N_SRC-1:0]  mask,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (sel)
      SEL_CAUSE: rd_mux = DATA_W'(cause);
      SEL_MASK:  rd_mux = DATA_W'(mask);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rd_en ? rd_mux : '0;
      rvalid <= rd_en;
    end
  end

endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int          N_SRC     = 7,
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter logic [7:0]  CAUSE_OFS = 8'h50,
  parameter logic [7:0]  MASK_OFS  = 8'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_out,
  output logic [$clog2(N_SRC)-1:0] irq_idx,
  output logic              irq_idx_vld
);

  localparam int IDX_W = $clog2(N_SRC);

  reg_sel_e         sel;
  logic             wr_cause, wr_mask, rd_en;
  logic [N_SRC-1:0] cause_q, mask_q, pending;

  always_comb begin
    if (bus_addr == ADDR_W'(CAUSE_OFS))     sel = SEL_CAUSE;
    else if (bus_addr == ADDR_W'(MASK_OFS)) sel = SEL_MASK;
    else                                    sel = SEL_NONE;
  end

  assign wr_cause = bus_en &  bus_we & (sel == SEL_CAUSE);
  assign wr_mask  = bus_en &  bus_we & (sel == SEL_MASK);
  assign rd_en    = bus_en & ~bus_we;

  irq_regfile #(.N_SRC(N_SRC)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cause(wr_cause),
    .wr_mask (wr_mask),
    .wdata   (bus_wdata[N_SRC-1:0]),
    .src_evt (src_evt),
    .cause_q (cause_q),
    .mask_q  (mask_q)
  );

  assign pending = cause_q & mask_q;
  assign irq_out = |pending;

  irq_prio_enc #(.N(N_SRC), .IDX_W(IDX_W)) u_prio (
    .vec(pending),
    .idx(irq_idx),
    .vld(irq_idx_vld)
  );

  irq_rd_port #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (rd_en),
    .sel   (sel),
    .cause (cause_q),
    .mask  (mask_q),
    .rdata (bus_rdata),
    .rvalid(bus_rvalid)
  );

endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk #(
  parameter int N_SRC  = 7,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  src_evt,
  input logic              bus_en,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              irq_out,
  input logic [IDX_W-1:0]  irq_idx,
  input logic              irq_idx_vld,
  input logic [N_SRC-1:0]  cause_q,
  input logic [N_SRC-1:0]  mask_q
);

  // R4 / R5: the OR output and the encoder flag must agree.
  p_line_matches_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == irq_idx_vld);

  p_idx_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_idx_vld |-> irq_idx == '0);

  // R6 / R7: every event bit is present one edge later, write or not.
  p_evt_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((cause_q & $past(src_evt)) == $past(src_evt)));

  // R9: read valid follows the request by exactly one cycle.
  p_rvalid_after_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> bus_rvalid);

  p_rvalid_only_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_we) |=> !bus_rvalid);

  p_read_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && src_evt == '0) |=> ($stable(cause_q) && $stable(mask_q)));

  // R8: unused upper bits never read as one.
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> bus_rdata[DATA_W-1:N_SRC] == '0);

endmodule

bind irq_cause_ctrl irq_cause_chk #(
  .N_SRC (N_SRC),
  .DATA_W(DATA_W),
  .IDX_W ($clog2(N_SRC))
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_evt    (src_evt),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .irq_out    (irq_out),
  .irq_idx    (irq_idx),
  .irq_idx_vld(irq_idx_vld),
  .cause_q    (cause_q),
  .mask_q     (mask_q)
);

// File: tb/sim_irq_cause_ctrl.sv
`timescale 1ns/1ps
module sim_irq_cause_ctrl;

  localparam logic [7:0] A_CAUSE = 8'h50;
  localparam logic [7:0] A_MASK  = 8'h54;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  src_evt = '0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_out;
  logic [2:0]  irq_idx;
  logic        irq_idx_vld;

  int n_run = 0;
  int n_fail = 0;
  logic [6:0] m_cause = '0;
  logic [6:0] m_mask = '0;

  always #2.5 clk = ~clk;

  irq_cause_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_out(irq_out), .irq_idx(irq_idx), .irq_idx_vld(irq_idx_vld)
  );

  function automatic logic [2:0] top_bit(input logic [6:0] v);
    logic [2:0] r = '0;
    for (int i = 0; i < 7; i++) if (v[i]) r = 3'(i);
    return r;
  endfunction

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    if (a == A_CAUSE) return {25'd0, m_cause};
    if (a == A_MASK)  return {25'd0, m_mask};
    return 32'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    logic [6:0] p = m_cause & m_mask;
    check({req, " R4 irq_out"}, 32'(irq_out), 32'(p != 0));
    check({req, " R5 idx_vld"}, 32'(irq_idx_vld), 32'(p != 0));
    check({req, " R5 idx"}, 32'(irq_idx), 32'(top_bit(p)));
  endtask

  // One bus cycle: drive at negedge, update model at posedge, check at next negedge.
  task automatic cycle(input logic en, input logic we, input logic [7:0] a,
                       input logic [31:0] d, input logic [6:0] ev, input string req);
    logic [31:0] exp_rd;
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; src_evt = ev;
    @(posedge clk);
    exp_rd = model_rd(a);
    if (en && we && a == A_CAUSE) m_cause = d[6:0];
    if (en && we && a == A_MASK)  m_mask  = d[6:0];
    m_cause = m_cause | ev;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; src_evt = '0;
    check_outs(req);
    check({req, " R9 rvalid"}, 32'(bus_rvalid), 32'(en && !we));
    if (en && !we) check({req, " R9/R8 rdata"}, bus_rdata, exp_rd);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq_out", 32'(irq_out), 0);
    check("R1 idx_vld", 32'(irq_idx_vld), 0);
    check("R1 idx", 32'(irq_idx), 0);
    check("R1 rvalid", 32'(bus_rvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cycle(1, 0, A_CAUSE, 0, 0, "R1 cause read");
    cycle(1, 0, A_MASK,  0, 0, "R1 mask read");

    // R2/R3: software raise while masked, then enable
    cycle(1, 1, A_CAUSE, 32'h0000_0012, 0, "R2 write cause");
    cycle(1, 0, A_CAUSE, 0, 0, "R2 read cause");
    cycle(1, 1, A_MASK, 32'h0000_0001, 0, "R3 mask blocks");
    cycle(1, 1, A_MASK, 32'h0000_007F, 0, "R3 unmask all");
    // R5: priority among several
    cycle(1, 1, A_CAUSE, 32'h0000_0045, 0, "R5 top is 6");
    cycle(1, 1, A_MASK, 32'h0000_0005, 0, "R5 top is 2");
    // R2: clear by writing zero
    cycle(1, 1, A_CAUSE, 32'h0000_0000, 0, "R2 clear");
    // R6: event on masked source sets cause but no irq
    cycle(0, 0, 0, 0, 7'h08, "R6 masked event");
    cycle(1, 0, A_CAUSE, 0, 0, "R6 read back");
    // R7: event during clearing write
    cycle(1, 1, A_CAUSE, 32'h0, 7'h01, "R7 collide");
    cycle(1, 0, A_CAUSE, 0, 0, "R7 read back");
    // R8: upper bits ignored
    cycle(1, 1, A_MASK, 32'hFFFF_FF80, 0, "R8 upper write");
    cycle(1, 0, A_MASK, 0, 0, "R8 read mask");
    cycle(1, 1, A_CAUSE, 32'hFFFF_FFFF, 0, "R8 all ones");
    cycle(1, 0, A_CAUSE, 0, 0, "R8 read cause");
    // R9: unmapped address
    cycle(1, 1, 8'h58, 32'h0000_007F, 0, "R9 unmapped write");
    cycle(1, 0, 8'h58, 0, 0, "R9 unmapped read");
    cycle(1, 0, A_MASK, 0, 7'h10, "R9 read old value");
    // R2/R3: both zero clears everything
    cycle(1, 1, A_CAUSE, 0, 0, "R2 zero cause");
    cycle(1, 1, A_MASK, 0, 0, "R3 zero mask");

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a;
      logic [6:0] ev;
      case ($urandom % 4)
        0: a = A_CAUSE;
        1: a = A_MASK;
        2: a = 8'h58;
        default: a = A_CAUSE;
      endcase
      ev = (($urandom % 4) == 0) ? 7'($urandom) : 7'd0;
      cycle(1'($urandom), 1'($urandom), a, $urandom, ev, "R2-random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule